// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter

This block is the request front end of a two-channel DMA controller. For each channel, a three-bit source code picks where transfer requests come from. The choices are an active-low external request pin, the serial receiver's "data full" signal, or the serial transmitter's "data empty" signal. A detected request is held as pending until the transfer engine reports the transfer that retires it. In cycle-steal mode that is the first transfer. In burst mode it is the transfer flagged as last.

When the engine is idle and at least one enabled channel has a request pending, the arbiter registers a grant and a channel index. It picks the channel by fixed priority (channel 0 first) or by round-robin, according to one control bit. The grant and index stay stable until the engine acknowledges the start of the transfer.

The block also flags illegal address pairings for serial-triggered channels. A receiver-triggered channel must read from the receive data register. A transmitter-triggered channel must write to the transmit data register.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant` is 0, `grant_ch` is 0, and no request is pending. Round-robin state starts as if channel 1 were the last channel granted.
- R2: With source code 3'b000, a high-to-low transition on `ext_req_n[i]` sets the pending request of channel i. The transition is seen at the first rising edge where the pin is sampled low after being sampled high there the edge before. A pin held low sets nothing further.
- R3: Source code 3'b001 sets pending on a rising edge of `rx_full`. Code 3'b010 sets pending on a rising edge of `tx_empty`. Any other code (3'b011 to 3'b111) never sets a pending request.
- R4: `cfg_err[i]` is 1 exactly when channel i is enabled and either its code is 3'b001 with `src_at_rdr[i]` = 0, or its code is 3'b010 with `dst_at_tdr[i]` = 0. It is combinational from the inputs.
- R5: With `burst_mode[i]` = 0 (cycle-steal), a `xfer_done` pulse with `xfer_ch` = i clears channel i's pending request.
- R6: With `burst_mode[i]` = 1, a `xfer_done` for channel i clears its pending request only when `xfer_last` = 1. Otherwise the request stays pending and is granted again.
- R7: With `rr_mode` = 0 and both channels pending, channel 0 is granted.
- R8: With `rr_mode` = 1 and both channels pending, the channel not granted most recently wins.
- R9: `grant` rises only at a rising edge where `eng_idle` = 1 and some enabled channel is pending. It appears one edge after the pending request is set. `grant` and `grant_ch` then hold until an edge with `eng_start` = 1, after which `grant` is 0.
- R10: A channel with `chan_en[i]` = 0 never receives a new grant. Its pending request is cleared, and request edges arriving while it is disabled are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 2 | Per-channel enable |
| src_sel0 | input | 3 | Request source code, channel 0 |
| src_sel1 | input | 3 | Request source code, channel 1 |
| burst_mode | input | 2 | Per-channel mode: 1 = burst, 0 = cycle-steal |
| rr_mode | input | 1 | 0 = fixed priority, 1 = round-robin |
| ext_req_n | input | 2 | External request pins, active-low, edge-detected |
| rx_full | input | 1 | Serial receiver data-full request |
| tx_empty | input | 1 | Serial transmitter data-empty request |
| src_at_rdr | input | 2 | Channel source address is the receive data register |
| dst_at_tdr | input | 2 | Channel destination address is the transmit data register |
| eng_idle | input | 1 | Transfer engine can accept a grant |
| eng_start | input | 1 | Engine acknowledges the grant and starts |
| xfer_done | input | 1 | One transfer finished |
| xfer_ch | input | 1 | Channel of the finished transfer |
| xfer_last | input | 1 | Finished transfer was the last of the block |
| grant | output | 1 | Registered grant to the engine |
| grant_ch | output | 1 | Registered index of the granted channel |
| cfg_err | output | 2 | Illegal address pairing per channel |

## Verification
A request edge driven between clock edges is captured as pending at the next rising edge. The grant follows one edge later, so the bench checks `grant` is still 0 one cycle after the stimulus and 1 two cycles after it. An `eng_start` drops the grant at the next edge. A pending request that a transfer retires is confirmed absent by raising `eng_idle` and seeing no grant two cycles later. `cfg_err` is combinational and is checked in the same cycle its inputs change. All inputs are driven and all outputs sampled on the falling clock edge.

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] chan_en,
  input  logic [2:0] src_sel0,
  input  logic [2:0] src_sel1,
  input  logic [1:0] burst_mode,
  input  logic       rr_mode,
  input  logic [1:0] ext_req_n,
  input  logic       rx_full,
  input  logic       tx_empty,
  input  logic [1:0] src_at_rdr,
  input  logic [1:0] dst_at_tdr,
  input  logic       eng_idle,
  input  logic       eng_start,
  input  logic       xfer_done,
  input  logic       xfer_ch,
  input  logic       xfer_last,
  output logic       grant,
  output logic       grant_ch,
  output logic [1:0] cfg_err
);

  localparam logic [2:0] SRC_PIN = 3'b000;
  localparam logic [2:0] SRC_RX  = 3'b001;
  localparam logic [2:0] SRC_TX  = 3'b010;

  logic [2:0] sel [2];
  logic [1:0] pin_q;
  logic       rx_q, tx_q;
  logic [1:0] pend, trig, clr, cand;
  logic       last_ch, pick;

  assign sel[0] = src_sel0;
  assign sel[1] = src_sel1;

  wire rx_rise = rx_full & ~rx_q;
  wire tx_rise = tx_empty & ~tx_q;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    always_comb begin
      case (sel[g])
        SRC_PIN: trig[g] = pin_q[g] & ~ext_req_n[g];
        SRC_RX:  trig[g] = rx_rise;
        SRC_TX:  trig[g] = tx_rise;
        default: trig[g] = 1'b0;
      endcase
    end

    assign clr[g] = xfer_done && (xfer_ch == 1'(g)) && (!burst_mode[g] || xfer_last);

    assign cfg_err[g] = chan_en[g] &&
                        ((sel[g] == SRC_RX && !src_at_rdr[g]) ||
                         (sel[g] == SRC_TX && !dst_at_tdr[g]));

    always_ff @(posedge clk) begin
      if (!rst_n || !chan_en[g]) pend[g] <= 1'b0;
      else if (trig[g])          pend[g] <= 1'b1;
      else if (clr[g])           pend[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 2'b11;
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      pin_q <= ext_req_n;
      rx_q  <= rx_full;
      tx_q  <= tx_empty;
    end
  end

  assign cand = pend & chan_en;
  assign pick = (cand == 2'b11) ? (rr_mode ? ~last_ch : 1'b0) : cand[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant    <= 1'b0;
      grant_ch <= 1'b0;
      last_ch  <= 1'b1;
    end else if (grant) begin
      if (eng_start) grant <= 1'b0;
    end else if (eng_idle && |cand) begin
      grant    <= 1'b1;
      grant_ch <= pick;
      last_ch  <= pick;
    end
  end

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chan_en,
  input logic [2:0] src_sel0,
  input logic [2:0] src_sel1,
  input logic       rr_mode,
  input logic       eng_idle,
  input logic       eng_start,
  input logic [1:0] pend,
  input logic       grant,
  input logic       grant_ch,
  input logic [1:0] cfg_err
);

  AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    grant && !eng_start |=> grant && $stable(grant_ch)); // R9

  AST_GRANT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    grant && eng_start |=> !grant); // R9

  AST_GRANT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(eng_idle)); // R9

  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(chan_en[grant_ch])); // R10

  AST_FIXED_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) && $past(!rr_mode && (pend & chan_en) == 2'b11) |-> grant_ch == 1'b0); // R7

  AST_CFG_ERR_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err[0] |-> chan_en[0] && (src_sel0 == 3'b001 || src_sel0 == 3'b010)); // R4

  AST_CFG_ERR_SERIAL1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err[1] |-> chan_en[1] && (src_sel1 == 3'b001 || src_sel1 == 3'b010)); // R4

endmodule

bind dma_req_arbiter dma_req_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .src_sel0(src_sel0),
  .src_sel1(src_sel1), .rr_mode(rr_mode), .eng_idle(eng_idle),
  .eng_start(eng_start), .pend(pend), .grant(grant), .grant_ch(grant_ch),
  .cfg_err(cfg_err)
);

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] chan_en = 2'b11, burst_mode = 0, ext_req_n = 2'b11;
  logic [1:0] src_at_rdr = 2'b11, dst_at_tdr = 2'b11, cfg_err;
  logic [2:0] src_sel0 = 0, src_sel1 = 0;
  logic rr_mode = 0, rx_full = 0, tx_empty = 0, eng_idle = 1, eng_start = 0;
  logic xfer_done = 0, xfer_ch = 0, xfer_last = 0, grant, grant_ch;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dma_req_arbiter uut (.*);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; chan_en = 2'b11; burst_mode = 0; ext_req_n = 2'b11;
    src_sel0 = 0; src_sel1 = 0; rr_mode = 0; rx_full = 0; tx_empty = 0;
    eng_idle = 1; eng_start = 0; xfer_done = 0; xfer_last = 0;
    src_at_rdr = 2'b11; dst_at_tdr = 2'b11;
    step(2); rst_n = 1; step(1);
  endtask

  task automatic ack();
    eng_start = 1; eng_idle = 0; step(1); eng_start = 0;
    check("R9 grant drops after start", grant, 0);
  endtask

  task automatic done(logic ch, logic last);
    xfer_done = 1; xfer_ch = ch; xfer_last = last; step(1);
    xfer_done = 0; xfer_last = 0; eng_idle = 1;
  endtask

  task automatic t_reset();
    rst_n = 0; step(2);
    check("R1 grant at reset", grant, 0);
    check("R1 grant_ch at reset", grant_ch, 0);
    do_reset();
    step(2);
    check("R1 nothing pending after reset", grant, 0);
  endtask

  task automatic t_pin_cycle_steal();
    do_reset();
    ext_req_n[0] = 0; step(1);
    check("R2 no grant one cycle after edge", grant, 0);
    step(1);
    check("R2 grant two cycles after edge", grant, 1);
    check("R2 grant_ch", grant_ch, 0);
    ack(); done(0, 0); step(2);
    check("R5 cycle-steal cleared on first transfer", grant, 0);
    step(3);
    check("R2 held low pin gives no new request", grant, 0);
    ext_req_n = 2'b11; step(1);
  endtask

  task automatic t_burst();
    do_reset();
    burst_mode = 2'b10;
    ext_req_n[1] = 0; step(2);
    check("R2 ch1 grant", grant, 1);
    check("R2 ch1 index", grant_ch, 1);
    ack(); done(1, 0); step(1);
    check("R6 burst pending kept without last", grant, 1);
    check("R6 regrant ch1", grant_ch, 1);
    ack(); done(1, 1); step(2);
    check("R6 burst cleared on last", grant, 0);
    ext_req_n = 2'b11; step(1);
  endtask

  task automatic t_prio(logic rr);
    do_reset();
    rr_mode = rr;
    ext_req_n[0] = 0; step(2);
    check(rr ? "R8 first grant ch0" : "R7 first grant ch0", grant_ch, 0);
    ack(); done(0, 0); ext_req_n = 2'b11; step(1);
    ext_req_n = 2'b00; step(2);
    check(rr ? "R8 both pending grant" : "R7 both pending grant", grant, 1);
    check(rr ? "R8 rotates to ch1" : "R7 fixed picks ch0", grant_ch, rr ? 1 : 0);
    ack(); done(grant_ch, 0); step(1);
    check(rr ? "R8 remaining ch0" : "R7 remaining ch1", grant_ch, rr ? 0 : 1);
    check("R9 remaining granted", grant, 1);
    ack(); done(grant_ch, 0);
    ext_req_n = 2'b11; step(1);
  endtask

  task automatic t_rr_reset_state();
    do_reset();
    rr_mode = 1; ext_req_n = 2'b00; step(2);
    check("R8 after reset ch0 wins", grant_ch, 0);
    ack(); done(0, 0); ext_req_n = 2'b11; step(1);
    ack(); done(1, 0); step(1);
  endtask

  task automatic t_serial();
    do_reset();
    src_sel0 = 3'b001; src_sel1 = 3'b010;
    tx_empty = 1; step(2);
    check("R3 tx_empty grants ch1", grant, 1);
    check("R3 tx_empty index", grant_ch, 1);
    ack(); done(1, 0); step(2);
    check("R3 ch0 ignores tx_empty", grant, 0);
    rx_full = 1; step(2);
    check("R3 rx_full grants ch0", grant_ch, 0);
    check("R3 rx_full grant", grant, 1);
    ack(); done(0, 0); rx_full = 0; tx_empty = 0; step(1);
    src_sel0 = 3'b011; src_sel1 = 3'b111;
    ext_req_n = 2'b00; rx_full = 1; tx_empty = 1; step(3);
    check("R3 reserved codes give no request", grant, 0);
    ext_req_n = 2'b11; rx_full = 0; tx_empty = 0; step(1);
  endtask

  task automatic t_cfg_err();
    do_reset();
    src_sel0 = 3'b001; src_at_rdr = 2'b00; step(1);
    check("R4 rx source not at RDR", cfg_err[0], 1);
    src_at_rdr = 2'b01; step(1);
    check("R4 rx source at RDR", cfg_err[0], 0);
    src_sel1 = 3'b010; dst_at_tdr = 2'b00; step(1);
    check("R4 tx dest not at TDR", cfg_err[1], 1);
    chan_en = 2'b01; step(1);
    check("R4 disabled channel no error", cfg_err[1], 0);
    src_sel0 = 3'b000; src_at_rdr = 2'b00; step(1);
    check("R4 pin source no error", cfg_err[0], 0);
  endtask

  task automatic t_disable_idle();
    do_reset();
    eng_idle = 0; ext_req_n[0] = 0; step(3);
    check("R9 no grant while busy", grant, 0);
    eng_idle = 1; step(1);
    check("R9 grant when idle", grant, 1);
    step(3);
    check("R9 grant held without start", grant, 1);
    check("R9 index held", grant_ch, 0);
    ack(); done(0, 0); ext_req_n = 2'b11; step(1);
    eng_idle = 0; ext_req_n[0] = 0; step(1);
    chan_en = 2'b10; step(1); chan_en = 2'b11; eng_idle = 1; step(2);
    check("R10 disable clears pending", grant, 0);
    ext_req_n = 2'b11; chan_en = 2'b10; step(1);
    ext_req_n[0] = 0; step(1); chan_en = 2'b11; step(2);
    check("R10 edge while disabled dropped", grant, 0);
    ext_req_n = 2'b11; step(1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pin_cycle_steal();
        t_burst();
        t_prio(0);
        t_prio(1);
        t_rr_reset_state();
        t_serial();
        t_cfg_err();
        t_disable_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule